// File: doc/BRIEF.md
# NAND Flash Hardware ECC Accumulator

This block sits beside a NAND flash data bus and builds a three-byte Hamming-style error code over each 256-byte data block while the bytes are transferred. A host drives a 2-bit mode field. The clear mode wipes the accumulated parity. The run mode folds each strobed data byte into the parity state. The idle mode freezes the state. The dump mode turns the shared data port into a readout port that returns the three code bytes on successive reads.

A typical sequence clears the state, then goes idle, then runs while a page half is moved over the bus. The host then goes idle, switches to dump, reads the port three times and goes idle again. The code is stored inverted, so an erased block (all 0xFF) produces 0xFF in every code byte. A single flipped bit moves the line and column parities in a way that names the bad byte and bit.

Top module: `nand_ecc_top`

## Requirements
- R1: The mode input `eccMode` is a level sampled at every clock edge. The encodings are 2'b00 idle, 2'b01 clear, 2'b10 run and 2'b11 dump.
- R2: A clock edge in clear mode sets all parity state and the byte position counter to zero. A dump after that returns 0xFF, 0xFF, 0xFF.
- R3: In run mode, each edge with `byteStrobe` high folds `busData` into the parity state. The byte is placed at the position given by the count of strobed bytes since the last clear, modulo 256, so a stream longer than 256 bytes wraps.
- R4: In idle mode the parity state and the position counter hold, and `byteStrobe` has no effect. A run resumed later continues at the held position.
- R5: Code layout. Code0 bit 2i+1 is the inverted XOR of the byte parities of all bytes whose position has bit i set, and code0 bit 2i is the same for bytes whose position has bit i clear, for i = 0..3. Code1 holds the same for i = 4..7. Code2 bits [7:2] are the inverted column parities CP5..CP0, and code2 bits [1:0] read as 1. CP(2k) is the XOR over all bytes of the data bits whose index has bit k clear, and CP(2k+1) is the same for bits whose index has bit k set, for k = 0..2.
- R6: In dump mode, reads (edges with `portRead` high) return code1, then code0, then code2, each on `portData` during the read cycle. A fourth read wraps back to code1.
- R7: Any edge outside dump mode returns the readout pointer to its start, so the next dump session begins with code1.
- R8: A full block of 256 bytes of 0xFF yields 0xFF in all three code bytes.
- R9: Data strobes in dump mode do not change the parity state.
- R10: Outside dump mode, `portData` equals `busData` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccMode | input | 2 | Mode field: idle, clear, run, dump |
| busData | input | 8 | Data byte on the flash bus |
| byteStrobe | input | 1 | A data byte is transferred this cycle |
| portRead | input | 1 | Host reads the data port this cycle |
| portData | output | 8 | Data port value: code byte in dump mode, otherwise bus data |

## Verification
The hardest case to reach from the ports is a block whose accumulation is broken up. Bytes arrive, the mode drops to idle while stray strobes carry junk data, and the run then resumes at the held position. The result must match an uninterrupted block. The bench reaches this by splitting a pseudo-random block at byte 100 and injecting junk strobes in idle mode. It also strobes junk during the dump reads, and it sweeps single-bit blocks over many positions and every bit index, so that each line and column parity bit is toggled alone.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int ECC_BYTES = 3;
  localparam int PTR_W     = 2;

  typedef enum logic [1:0] {
    ECC_IDLE  = 2'b00,
    ECC_CLEAR = 2'b01,
    ECC_RUN   = 2'b10,
    ECC_DUMP  = 2'b11
  } eccMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearState;
    logic             accumByte;
    logic             dumpActive;
    logic [PTR_W-1:0] dumpSel;
  } eccCtrl_t;

  // readout order: slot 0 -> code1, slot 1 -> code0, slot 2 -> code2
  function automatic int dumpByteIndex(input logic [PTR_W-1:0] slot);
    case (slot)
      2'd0:    return 1;
      2'd1:    return 0;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       byteStrobe,
  input  logic       portRead,
  output eccCtrl_t   ctrlS
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ECC_BYTES - 1);

  eccMode_e         modeNow;
  logic [PTR_W-1:0] ptrQ;

  assign modeNow = eccMode_e'(modeSel);

  // readout pointer: parked at slot 0 outside dump mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (modeNow != ECC_DUMP) begin
      ptrQ <= '0;
    end else if (portRead) begin
      ptrQ <= (ptrQ == LAST_SLOT) ? '0 : ptrQ + 1'b1;
    end
  end

  always_comb begin
    ctrlS            = '0;
    ctrlS.clearState = (modeNow == ECC_CLEAR);
    ctrlS.accumByte  = (modeNow == ECC_RUN) && byteStrobe;
    ctrlS.dumpActive = (modeNow == ECC_DUMP);
    ctrlS.dumpSel    = ptrQ;
  end

endmodule

// File: rtl/nand_ecc_dp.sv
module nand_ecc_dp
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  eccCtrl_t                    ctrlS,
  input  logic [DATA_W-1:0]           busData,
  output logic [DATA_W-1:0]           portData,
  output logic [DATA_W*ECC_BYTES-1:0] codeVec
);

  localparam int ADDR_W = $clog2(BLOCK_BYTES);
  localparam int LINE_W = 2 * ADDR_W;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int COL_W  = 2 * IDX_W;
  localparam int CODE_W = DATA_W * ECC_BYTES;
  localparam int PAD_W  = CODE_W - LINE_W - COL_W;

  // bits of a data word whose index has bit k equal to v
  function automatic logic [DATA_W-1:0] colMask(input int k, input bit v);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int j = 0; j < DATA_W; j++) begin
      m[j] = (((j >> k) & 1) == int'(v));
    end
    return m;
  endfunction

  logic [ADDR_W-1:0] posQ;
  logic [LINE_W-1:0] lineQ;
  logic [COL_W-1:0]  colQ;
  logic              byteParity;

  assign byteParity = ^busData;

  // byte position inside the block
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
    end else if (ctrlS.clearState) begin
      posQ <= '0;
    end else if (ctrlS.accumByte) begin
      posQ <= posQ + 1'b1;
    end
  end

  // line parity: one true/complement pair per position bit
  for (genvar i = 0; i < ADDR_W; i++) begin : g_line
    logic [1:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellQ <= '0;
      end else if (ctrlS.clearState) begin
        cellQ <= '0;
      end else if (ctrlS.accumByte) begin
        if (posQ[i]) cellQ[1] <= cellQ[1] ^ byteParity;
        else         cellQ[0] <= cellQ[0] ^ byteParity;
      end
    end
    assign lineQ[2*i +: 2] = cellQ;
  end

  // column parity: one pair per bit-index bit
  for (genvar k = 0; k < IDX_W; k++) begin : g_col
    localparam logic [DATA_W-1:0] MASK_LO = colMask(k, 1'b0);
    localparam logic [DATA_W-1:0] MASK_HI = colMask(k, 1'b1);
    logic [1:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellQ <= '0;
      end else if (ctrlS.clearState) begin
        cellQ <= '0;
      end else if (ctrlS.accumByte) begin
        cellQ[0] <= cellQ[0] ^ (^(busData & MASK_LO));
        cellQ[1] <= cellQ[1] ^ (^(busData & MASK_HI));
      end
    end
    assign colQ[2*k +: 2] = cellQ;
  end

  // stored inverted so an erased block gives all-ones code
  assign codeVec = {~colQ, {PAD_W{1'b1}}, ~lineQ};

  always_comb begin
    portData = busData;
    if (ctrlS.dumpActive) begin
      portData = codeVec[DATA_W*dumpByteIndex(ctrlS.dumpSel) +: DATA_W];
    end
  end

endmodule

// File: rtl/nand_ecc_top.sv
module nand_ecc_top
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        eccMode,
  input  logic [DATA_W-1:0] busData,
  input  logic              byteStrobe,
  input  logic              portRead,
  output logic [DATA_W-1:0] portData
);

  eccCtrl_t                    ctrlS;
  logic [DATA_W*ECC_BYTES-1:0] codeVec;

  nand_ecc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (eccMode),
    .byteStrobe (byteStrobe),
    .portRead   (portRead),
    .ctrlS      (ctrlS)
  );

  nand_ecc_dp #(
    .DATA_W      (DATA_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlS    (ctrlS),
    .busData  (busData),
    .portData (portData),
    .codeVec  (codeVec)
  );

endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [1:0]                  eccMode,
  input logic [DATA_W-1:0]           busData,
  input logic                        byteStrobe,
  input logic                        portRead,
  input logic [DATA_W-1:0]           portData,
  input eccCtrl_t                    ctrlS,
  input logic [DATA_W*ECC_BYTES-1:0] codeVec
);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    eccMode == ECC_CLEAR |=> codeVec == {(DATA_W*ECC_BYTES){1'b1}});

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    eccMode == ECC_IDLE |=> $stable(codeVec));

  p_dump_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    eccMode == ECC_DUMP |=> $stable(codeVec));

  p_run_nostrobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (eccMode == ECC_RUN && !byteStrobe) |=> $stable(codeVec));

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.dumpSel != 2'd3);

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eccMode == ECC_DUMP && portRead && ctrlS.dumpSel != 2'd2)
      |=> ctrlS.dumpSel == $past(ctrlS.dumpSel) + 2'd1);

  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eccMode == ECC_DUMP && portRead && ctrlS.dumpSel == 2'd2)
      |=> ctrlS.dumpSel == 2'd0);

  p_ptr_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    eccMode != ECC_DUMP |=> ctrlS.dumpSel == 2'd0);

  p_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    eccMode != ECC_DUMP |-> portData == busData);

endmodule

bind nand_ecc_top nand_ecc_chk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .eccMode    (eccMode),
  .busData    (busData),
  .byteStrobe (byteStrobe),
  .portRead   (portRead),
  .portData   (portData),
  .ctrlS      (ctrlS),
  .codeVec    (codeVec)
);

// File: tb/tb_nand_ecc_top.sv
module tb_nand_ecc_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] eccMode = 2'b00;
  logic [7:0] busData = 8'h00;
  logic       byteStrobe = 1'b0;
  logic       portRead = 1'b0;
  logic [7:0] portData;

  int checks = 0;
  int failures = 0;

  logic [7:0] blk [0:511];

  always #5 clk = ~clk;

  nand_ecc_top dut (
    .clk        (clk),
    .rstN       (rstN),
    .eccMode    (eccMode),
    .busData    (busData),
    .byteStrobe (byteStrobe),
    .portRead   (portRead),
    .portData   (portData)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // expected code {code2, code1, code0} from the R5 layout
  function automatic logic [23:0] refEcc(input int n);
    logic [15:0] line = '0;
    logic [5:0]  col = '0;
    for (int a = 0; a < n; a++) begin
      logic [7:0] b = blk[a];
      logic [7:0] pos = 8'(a % 256);
      logic       p = ^b;
      for (int i = 0; i < 8; i++) begin
        if (pos[i]) line[2*i+1] ^= p;
        else        line[2*i]   ^= p;
      end
      for (int k = 0; k < 3; k++) begin
        for (int j = 0; j < 8; j++) begin
          col[2*k + ((j >> k) & 1)] ^= b[j];
        end
      end
    end
    return {~col, 2'b11, ~line};
  endfunction

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    eccMode = m; byteStrobe = 1'b0; portRead = 1'b0;
  endtask

  task automatic startCalc();
    setMode(2'b01); setMode(2'b00); setMode(2'b10);
  endtask

  task automatic feed(input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      eccMode = 2'b10; busData = blk[i]; byteStrobe = 1'b1;
    end
    @(negedge clk);
    byteStrobe = 1'b0;
  endtask

  // idle, dump three reads (optionally with junk strobes), idle
  task automatic readCode(input logic [23:0] exp, input bit junk, input string req);
    setMode(2'b00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      eccMode = 2'b11; portRead = 1'b1;
      byteStrobe = junk; busData = 8'hC3 ^ 8'(k);
      #1;
      case (k)
        0: chk({req, " R6 first=code1"}, portData, exp[15:8]);
        1: chk({req, " R6 second=code0"}, portData, exp[7:0]);
        default: chk({req, " R6 third=code2"}, portData, exp[23:16]);
      endcase
    end
    setMode(2'b00);
  endtask

  task automatic fillLfsr(input logic [15:0] seed);
    logic [15:0] s = seed;
    for (int i = 0; i < 512; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      blk[i] = s[7:0] ^ s[15:8];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state and pass-through (R1, R10)
    @(negedge clk);
    busData = 8'h5A; #1;
    chk("R10 R1 idle pass-through", portData, 8'h5A);
    readCode(24'hFFFFFF, 1'b0, "R2 after reset");

    // erased block (R8)
    for (int i = 0; i < 512; i++) blk[i] = 8'hFF;
    startCalc(); feed(0, 256);
    readCode(24'hFFFFFF, 1'b0, "R8 erased");

    // incrementing block, with pass-through in run mode
    for (int i = 0; i < 512; i++) blk[i] = 8'(i);
    startCalc();
    @(negedge clk); busData = 8'h96; #1;
    chk("R10 run pass-through", portData, 8'h96);
    feed(0, 256);
    readCode(refEcc(256), 1'b0, "R3 R5 incrementing");

    // pseudo-random block
    fillLfsr(16'hACE1);
    startCalc(); feed(0, 256);
    readCode(refEcc(256), 1'b0, "R3 random");

    // single-bit sweep over positions and every bit index (R5)
    for (int p = 0; p < 256; p += 37) begin
      for (int b = 0; b < 8; b++) begin
        for (int i = 0; i < 512; i++) blk[i] = 8'h00;
        blk[p] = 8'(1 << b);
        startCalc(); feed(0, 256);
        readCode(refEcc(256), 1'b0, "R5 single bit");
      end
    end

    // interrupted block with junk strobes in idle mode (R4)
    fillLfsr(16'h1D2B);
    startCalc(); feed(0, 100);
    setMode(2'b00);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      eccMode = 2'b00; busData = 8'(i * 13 + 7); byteStrobe = 1'b1;
      #1;
      if (i == 0) chk("R4 R10 idle pass-through", portData, 8'(7));
    end
    feed(100, 156);
    e = refEcc(256);
    // junk strobes during dump must not disturb (R9)
    readCode(e, 1'b1, "R4 R9 resumed");
    readCode(e, 1'b0, "R9 after junk strobes");

    // wrap on fourth read (R6)
    setMode(2'b00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); eccMode = 2'b11; portRead = 1'b1; #1;
      if (k == 3) chk("R6 fourth read wraps", portData, e[15:8]);
    end
    // leave after one read, reenter: starts at code1 (R7)
    setMode(2'b00);
    @(negedge clk); eccMode = 2'b11; portRead = 1'b1;
    @(negedge clk); eccMode = 2'b00; portRead = 1'b0;
    readCode(e, 1'b0, "R7 reentry");

    // partial and overlong blocks (R3 wrap)
    fillLfsr(16'h7777);
    startCalc(); feed(0, 100);
    readCode(refEcc(100), 1'b0, "R3 partial");
    startCalc(); feed(0, 300);
    readCode(refEcc(300), 1'b0, "R3 wrap past 256");

    // clear after data (R2)
    startCalc();
    readCode(24'hFFFFFF, 1'b0, "R2 clear");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule